// File: doc/BRIEF.md
# Event Line Access-Protection Register File

This block is the register file that guards a 29-line external event controller. It holds three word-wide registers: a per-line security configuration, a per-line privilege configuration and a per-line pending flag set. Every bus access carries a secure attribute and a privileged attribute. The block uses these two attributes, together with the stored privilege bits, to decide which bits a write may change and which bits a read may see. The decision is made bit by bit where the line's own configuration matters, and register by register where the whole register is protected.

Each pending flag is raised by a one-cycle set pulse from the line's edge detector. Software clears a flag by writing 1 to it. When a write is refused as a whole, or when an access is not a full word, the block emits a one-cycle illegal-access pulse. A security monitor can count or trap that pulse. The stored configuration and pending vectors are also driven out for the rest of the event controller to use.

Top module: `line_prot_regs`

## Requirements
- R1: After reset, the security, privilege and pending registers are all zero and `illegal_o` is low.
- R2: Bits 31:29 of every read are zero. Writing those bits stores nothing.
- R3: The security register is at offset 0x18. A secure write updates it. A non-secure write leaves the whole register unchanged and raises the illegal pulse.
- R4: The privilege register is at offset 0x1C. A privileged write updates it. An unprivileged write leaves it unchanged and raises the illegal pulse.
- R5: Reads of the security and privilege registers return the stored contents whatever the secure and privileged attributes of the access are.
- R6: A secure, unprivileged write to the security register changes only the bits whose privilege bit is 0. The other bits keep their value, and no illegal pulse is raised.
- R7: The pending register is at offset 0x14. A set pulse on a line raises that line's bit. Writing 1 to a bit clears it. Writing 0 leaves it unchanged.
- R8: For an unprivileged access, pending bits whose privilege bit is 1 read as 0 and are not cleared by a write of 1. No illegal pulse is raised for this case.
- R9: If a set pulse and a write-1 clear hit the same pending bit in the same cycle, the bit ends up set.
- R10: An access whose byte enables are not all 1 (`be_i` not 4'hF) changes nothing, reads 0 and raises the illegal pulse.
- R11: `illegal_o` is high for exactly the one cycle after the clock edge that samples a refused access. It is low after any access that was not refused.
- R12: A write to an offset other than 0x14, 0x18 or 0x1C changes nothing and raises no illegal pulse. A read from such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte offset of the register |
| be_i | input | 4 | Byte enables |
| wdata_i | input | 32 | Write data |
| secure_i | input | 1 | Access is secure |
| priv_i | input | 1 | Access is privileged |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| line_set_i | input | 29 | Per-line pending set pulses |
| sec_cfg_o | output | 29 | Stored security bits |
| priv_cfg_o | output | 29 | Stored privilege bits |
| pend_o | output | 29 | Stored pending flags |
| illegal_o | output | 1 | Illegal-access pulse |

## Verification
The bench aims at the points where two attributes interact:
- **Secure but unprivileged writes.** A design that gated the security register on the secure attribute alone would overwrite bits reserved to privileged code. A design that refused the write as a whole would leave bits unchanged that should have changed.
- **Unprivileged pending reads and clears.** A design that skipped the privilege mask would show protected flags as 1, or would clear them.
- **Set and clear in the same cycle.** If the clear won, a line event would be lost.
- **Partial-word and unmapped accesses.** Here a mixed-up decode shows as a stray pulse, a missing pulse or non-zero read data.
- **Pulse length.** A pulse that stayed high for more than one cycle fails the check made on the idle cycle that follows.

// File: rtl/line_prot_pkg.sv
package line_prot_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned BE_W   = DATA_W / 8;

  typedef struct packed {
    logic hit_sec;
    logic hit_priv;
    logic hit_pend;
    logic rd;
    logic wr_sec;
    logic wr_priv;
    logic wr_pend;
    logic refuse;
  } acc_t;
endpackage

// File: rtl/lp_access.sv
module lp_access
  import line_prot_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned OFF_PEND = 'h14,
  parameter int unsigned OFF_SEC  = 'h18,
  parameter int unsigned OFF_PRIV = 'h1C
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic              secure_i,
  input  logic              priv_i,
  output acc_t              acc_o
);
  logic word;
  logic act;

  always_comb begin
    word           = (be_i == {BE_W{1'b1}});
    act            = req_i & word;
    acc_o.hit_sec  = (addr_i == ADDR_W'(OFF_SEC));
    acc_o.hit_priv = (addr_i == ADDR_W'(OFF_PRIV));
    acc_o.hit_pend = (addr_i == ADDR_W'(OFF_PEND));
    acc_o.rd       = act & ~we_i;
    acc_o.wr_sec   = act & we_i & acc_o.hit_sec & secure_i;
    acc_o.wr_priv  = act & we_i & acc_o.hit_priv & priv_i;
    acc_o.wr_pend  = act & we_i & acc_o.hit_pend;
    // whole-register refusals; per-bit masking is not a refusal
    acc_o.refuse   = req_i & (~word
                   | (we_i & acc_o.hit_sec  & ~secure_i)
                   | (we_i & acc_o.hit_priv & ~priv_i));
  end
endmodule

// File: rtl/lp_cfg_reg.sv
module lp_cfg_reg #(
  parameter int unsigned N = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [N-1:0] bit_mask_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         q_o[k] <= 1'b0;
      else if (wr_en_i && bit_mask_i[k])   q_o[k] <= wdata_i[k];
    end
  end
endmodule

// File: rtl/lp_pend_reg.sv
module lp_pend_reg #(
  parameter int unsigned N = 29
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [N-1:0] clr_mask_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] q_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        q_o[k] <= 1'b0;
      else if (set_i[k])  q_o[k] <= 1'b1;  // set beats clear
      else if (clr_en_i && clr_mask_i[k] && wdata_i[k]) q_o[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/line_prot_regs.sv
module line_prot_regs
  import line_prot_pkg::*;
#(
  parameter int unsigned NUM_LINES = 29,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned OFF_PEND  = 'h14,
  parameter int unsigned OFF_SEC   = 'h18,
  parameter int unsigned OFF_PRIV  = 'h1C
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [BE_W-1:0]      be_i,
  input  logic [DATA_W-1:0]    wdata_i,
  input  logic                 secure_i,
  input  logic                 priv_i,
  output logic [DATA_W-1:0]    rdata_o,
  input  logic [NUM_LINES-1:0] line_set_i,
  output logic [NUM_LINES-1:0] sec_cfg_o,
  output logic [NUM_LINES-1:0] priv_cfg_o,
  output logic [NUM_LINES-1:0] pend_o,
  output logic                 illegal_o
);
  localparam int unsigned PAD_W = DATA_W - NUM_LINES;
  localparam logic [NUM_LINES-1:0] ALL = {NUM_LINES{1'b1}};

  acc_t                 acc;
  logic [NUM_LINES-1:0] wd;
  logic [NUM_LINES-1:0] vis_mask;
  logic [NUM_LINES-1:0] rd_sel;
  logic                 illegal_q;

  assign wd       = wdata_i[NUM_LINES-1:0];
  // lines reachable by this access: all if privileged, else unprotected ones
  assign vis_mask = priv_i ? ALL : ~priv_cfg_o;

  lp_access #(
    .ADDR_W(ADDR_W), .OFF_PEND(OFF_PEND), .OFF_SEC(OFF_SEC), .OFF_PRIV(OFF_PRIV)
  ) u_access (
    .req_i(req_i), .we_i(we_i), .addr_i(addr_i), .be_i(be_i),
    .secure_i(secure_i), .priv_i(priv_i), .acc_o(acc)
  );

  lp_cfg_reg #(.N(NUM_LINES)) u_sec (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(acc.wr_sec),
    .bit_mask_i(vis_mask), .wdata_i(wd), .q_o(sec_cfg_o)
  );

  lp_cfg_reg #(.N(NUM_LINES)) u_priv (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(acc.wr_priv),
    .bit_mask_i(ALL), .wdata_i(wd), .q_o(priv_cfg_o)
  );

  lp_pend_reg #(.N(NUM_LINES)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(line_set_i), .clr_en_i(acc.wr_pend),
    .clr_mask_i(vis_mask), .wdata_i(wd), .q_o(pend_o)
  );

  always_comb begin
    rd_sel = '0;
    if (acc.rd) begin
      unique case (1'b1)
        acc.hit_sec:  rd_sel = sec_cfg_o;
        acc.hit_priv: rd_sel = priv_cfg_o;
        acc.hit_pend: rd_sel = pend_o & vis_mask;
        default:      rd_sel = '0;
      endcase
    end
    rdata_o = {{PAD_W{1'b0}}, rd_sel};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= acc.refuse;
  end
  assign illegal_o = illegal_q;

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o >> NUM_LINES) == '0) else $error("reserved bits set"); // R2
  AST_SEC_NS_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_SEC) && !secure_i)
      |=> ($stable(sec_cfg_o) && illegal_o)) else $error("ns sec write"); // R3
  AST_PRIV_UNPRIV_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_PRIV) && !priv_i)
      |=> ($stable(priv_cfg_o) && illegal_o)) else $error("unpriv priv write"); // R4
  AST_SEC_BIT_GUARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_SEC) && !priv_i)
      |=> (((sec_cfg_o ^ $past(sec_cfg_o)) & $past(priv_cfg_o)) == '0)) else $error("sec bit guard"); // R6
  AST_PEND_RD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFF_PEND) && !priv_i)
      |-> ((rdata_o[NUM_LINES-1:0] & priv_cfg_o) == '0)) else $error("pend read mask"); // R8
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|line_set_i) |=> ((pend_o & $past(line_set_i)) == $past(line_set_i))) else $error("set lost"); // R9
  AST_PARTIAL_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && be_i != {BE_W{1'b1}}) |-> (rdata_o == '0) ##1 illegal_o) else $error("partial access"); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !illegal_o) else $error("stray pulse"); // R11
endmodule

// File: tb/line_prot_regs_tb.sv
module line_prot_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [28:0] ALL = 29'h1FFF_FFFF;
  localparam logic [7:0] A_PEND = 8'h14, A_SEC = 8'h18, A_PRIV = 8'h1C;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        req_i = 0, we_i = 0, secure_i = 0, priv_i = 0;
  logic [7:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [28:0] line_set_i = '0, sec_cfg_o, priv_cfg_o, pend_o;
  logic        illegal_o;

  int total = 0, bad = 0;
  logic [28:0] m_sec = '0, m_priv = '0, m_pend = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_prot_regs dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .be_i(be_i), .wdata_i(wdata_i), .secure_i(secure_i), .priv_i(priv_i),
    .rdata_o(rdata_o), .line_set_i(line_set_i), .sec_cfg_o(sec_cfg_o),
    .priv_cfg_o(priv_cfg_o), .pend_o(pend_o), .illegal_o(illegal_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic we, input logic [7:0] a,
                                           input logic [3:0] be, input logic prv);
    logic [28:0] v = '0;
    if (!we && be == 4'hF) begin
      if (a == A_SEC)       v = m_sec;
      else if (a == A_PRIV) v = m_priv;
      else if (a == A_PEND) v = m_pend & (prv ? ALL : ~m_priv);
    end
    return {3'b000, v};
  endfunction

  function automatic logic exp_refuse(input logic we, input logic [7:0] a,
                                      input logic [3:0] be, input logic sec, input logic prv);
    return (be != 4'hF) || (we && a == A_SEC && !sec) || (we && a == A_PRIV && !prv);
  endfunction

  // drive at negedge, check read in-cycle, update model, check state after edge
  task automatic do_op(input logic we, input logic [7:0] a, input logic [31:0] wd,
                       input logic [3:0] be, input logic sec, input logic prv,
                       input logic [28:0] set, input string tag);
    logic [28:0] mask, clr;
    logic ref_exp;
    req_i = 1; we_i = we; addr_i = a; wdata_i = wd; be_i = be;
    secure_i = sec; priv_i = prv; line_set_i = set;
    #1;
    chk({tag, " rdata"}, rdata_o, exp_read(we, a, be, prv));
    ref_exp = exp_refuse(we, a, be, sec, prv);
    mask = prv ? ALL : ~m_priv;
    clr = '0;
    if (we && be == 4'hF) begin
      if (a == A_SEC && sec)   m_sec = (m_sec & ~mask) | (wd[28:0] & mask);
      if (a == A_PRIV && prv)  m_priv = wd[28:0];
      if (a == A_PEND)         clr = wd[28:0] & mask;
    end
    m_pend = (m_pend & ~clr) | set;
    @(negedge clk);
    chk({tag, " illegal"}, {31'b0, illegal_o}, {31'b0, ref_exp});
    chk({tag, " sec"},  {3'b0, sec_cfg_o},  {3'b0, m_sec});
    chk({tag, " priv"}, {3'b0, priv_cfg_o}, {3'b0, m_priv});
    chk({tag, " pend"}, {3'b0, pend_o},     {3'b0, m_pend});
    req_i = 0; line_set_i = '0;
  endtask

  task automatic idle(input string tag);
    req_i = 0; line_set_i = '0;
    @(negedge clk);
    chk({tag, " idle illegal"}, {31'b0, illegal_o}, 32'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sec", {3'b0, sec_cfg_o}, 32'd0);
    chk("R1 priv", {3'b0, priv_cfg_o}, 32'd0);
    chk("R1 pend", {3'b0, pend_o}, 32'd0);
    chk("R1 illegal", {31'b0, illegal_o}, 32'd0);
    rst_ni = 1;
    @(negedge clk);

    do_op(1, A_PRIV, 32'hFFFF_FFFF, 4'hF, 1, 0, '0, "R4 unpriv");
    chk("R4 priv kept", {3'b0, priv_cfg_o}, 32'd0);
    do_op(1, A_PRIV, 32'hE000_00FF, 4'hF, 1, 1, '0, "R4 priv");
    chk("R4 priv written", {3'b0, priv_cfg_o}, 32'h0000_00FF);
    idle("R11");
    do_op(1, A_SEC, 32'hFFFF_FFFF, 4'hF, 0, 1, '0, "R3 nonsecure");
    chk("R3 sec kept", {3'b0, sec_cfg_o}, 32'd0);
    do_op(1, A_SEC, 32'hFFFF_FFFF, 4'hF, 1, 0, '0, "R6 unpriv");
    chk("R6 sec masked", {3'b0, sec_cfg_o}, 32'h1FFF_FF00);
    do_op(1, A_SEC, 32'hFFFF_FFFF, 4'hF, 1, 1, '0, "R3 secure");
    do_op(0, A_SEC, 32'd0, 4'hF, 0, 0, '0, "R5 ns read");
    chk("R2 R5 sec read", {3'b0, sec_cfg_o}, 32'h1FFF_FFFF);
    do_op(0, A_PRIV, 32'd0, 4'hF, 0, 0, '0, "R5 priv read");

    do_op(0, A_PEND, 32'd0, 4'hF, 1, 1, ALL, "R7 set");
    chk("R7 all set", {3'b0, pend_o}, 32'h1FFF_FFFF);
    do_op(0, A_PEND, 32'd0, 4'hF, 1, 0, '0, "R8 masked read");
    do_op(1, A_PEND, 32'hFFFF_FFFF, 4'hF, 1, 0, '0, "R8 unpriv clear");
    chk("R8 protected kept", {3'b0, pend_o}, 32'h0000_00FF);
    do_op(1, A_PEND, 32'd0, 4'hF, 1, 1, '0, "R7 write zero");
    chk("R7 unchanged", {3'b0, pend_o}, 32'h0000_00FF);
    do_op(1, A_PEND, 32'h0000_0003, 4'hF, 1, 1, 29'h1, "R9 set vs clear");
    chk("R9 bit0 set", {31'b0, pend_o[0]}, 32'd1);
    chk("R7 bit1 cleared", {31'b0, pend_o[1]}, 32'd0);

    do_op(1, A_PRIV, 32'd0, 4'h3, 1, 1, '0, "R10 partial write");
    chk("R10 priv kept", {3'b0, priv_cfg_o}, 32'h0000_00FF);
    idle("R11 after refusal");
    do_op(0, A_SEC, 32'd0, 4'h1, 1, 1, '0, "R10 partial read");
    do_op(1, 8'h20, 32'hFFFF_FFFF, 4'hF, 0, 0, '0, "R12 unmapped write");
    do_op(0, 8'h04, 32'd0, 4'hF, 1, 1, '0, "R12 unmapped read");
    chk("R2 reserved", {29'b0, rdata_o[31:29]}, 32'd0);

    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      logic [3:0] be;
      logic [28:0] set;
      int sel = $urandom_range(0, 9);
      a = (sel < 3) ? A_PEND : (sel < 6) ? A_SEC : (sel < 8) ? A_PRIV : 8'($urandom_range(0, 63) * 4);
      be = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      set = ($urandom_range(0, 3) == 0) ? 29'($urandom & $urandom & $urandom) : '0;
      do_op(1'($urandom), a, $urandom, be, 1'($urandom), 1'($urandom), set, "rand R3 R6 R7 R8");
      if ($urandom_range(0, 7) == 0) idle("rand R11");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule